// File: doc/BRIEF.md
# Exception Entry Bus Sequencer

This block drives the bus-cycle sequence a small processor runs when it enters an exception. Three kinds of entry are handled: a reset, an external interrupt and a software trap. When a request is accepted, the block captures the current program counter, the stack pointer, the extended status word and a vector number. It then runs a fixed list of steps on a word-wide bus master port. Each step is either a bus cycle or a single internal (idle) state.

A bus cycle presents an address, a write enable, a size flag, a lock flag and write data. It holds them until the bus returns an acknowledge. For an interrupt or a trap, the block pushes three words onto a stack that grows downward. It then fetches a 32-bit handler address from a vector table in two halves, high half first. The first handler instruction fetch ends the sequence. A reset skips the pushes. A reset request overrides any sequence that is in progress.

Top module: `exc_entry_seq`

## Requirements
- R1: A reset request (kind code 0) produces exactly these steps: a locked read at the reset vector address (the table base, address 0 by default), a read at that address + 2, one internal state, and a read at the handler address. No write occurs.
- R2: An interrupt request (kind code 1) produces these steps in this order: a read at PC + 2, one internal state, three word writes, a locked vector read, a read at vector + 2, one internal state, and the handler fetch.
- R3: If an interrupt is accepted with the wake flag set, the first step becomes one internal state with no bus request. Every internal state lasts exactly one cycle.
- R4: A trap request (kind code 2) follows the interrupt sequence, except that its first step is a plain read at PC itself. The wake flag has no effect on a trap.
- R5: Each push first lowers the stack pointer by 2 and then writes at the new value. The three pushes write PC bits 15:0 at SP-2, PC bits 31:16 at SP-4 and the extended status word at SP-6. The stack pointer output ends at SP-6.
- R6: The vector address for an interrupt or a trap is table base + 4 x vector number. Only the first vector read has the lock flag set. Every cycle is word-sized (size output = 1).
- R7: A bus cycle keeps its request, address, direction and data unchanged until the acknowledge is sampled high. The sequence does not advance while it waits.
- R8: The handler address is {word read at the vector, word read at vector + 2}. The done output pulses for exactly the cycle in which the handler fetch is acknowledged. The PC output then holds the handler address.
- R9: A reset request that arrives during any other sequence abandons that sequence. The next cycle starts the reset sequence at its first step.
- R10: An interrupt or trap request that arrives while busy is ignored, and so is kind code 3 at any time. The running sequence and its captured operands are unaffected.
- R11: After the reset input is asserted, the block is idle: no bus request, busy low, idle-state low and done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Entry request strobe |
| req_kind | input | 2 | 0 reset, 1 interrupt, 2 trap, 3 none |
| wake_from_sleep | input | 1 | Interrupt follows a low-power state |
| pc_in | input | AW | Program counter to save |
| sp_in | input | AW | Stack pointer at entry |
| xsr_in | input | DW | Extended status word to save |
| vec_num | input | VW | Vector number |
| bus_req | output | 1 | Bus cycle active |
| bus_addr | output | AW | Byte address |
| bus_we | output | 1 | 1 write, 0 read |
| bus_size | output | 1 | 1 word access |
| bus_lock | output | 1 | Locked read-modify cycle |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ack | input | 1 | Cycle acknowledge |
| idle_state | output | 1 | Internal state in progress |
| busy | output | 1 | Sequence running |
| done | output | 1 | Handler fetch completing |
| pc_out | output | AW | Handler start address |
| sp_out | output | AW | Stack pointer after pushes |

## Verification
The scoreboard checks every completed bus cycle and every internal state against the expected order. A design that swapped the push order, used the wrong prefetch address, or set the lock flag on both vector reads therefore fails on the first step that differs. The bench wakes an interrupt from sleep while the acknowledge is stretched. A design that kept the prefetch read, or that let its outputs drift while it waited, shows an extra bus cycle or an address change. A reset is injected in the middle of a push. A design that finished the push, or joined the reset steps partway through, fails the comparison. The bench also checks the highest vector number and requests that arrive while busy, which catch address overflow and operand corruption.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   typedef enum logic [1:0] {
      KIND_RESET = 2'd0,
      KIND_IRQ   = 2'd1,
      KIND_TRAP  = 2'd2,
      KIND_NONE  = 2'd3
   } kind_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FIRST,
      ST_GAP1,
      ST_PUSH_LO,
      ST_PUSH_HI,
      ST_PUSH_X,
      ST_VEC_HI,
      ST_VEC_LO,
      ST_GAP2,
      ST_FETCH
   } step_e;

   // successor of each step along the fixed entry list
   function automatic step_e step_after(step_e s);
      case (s)
         ST_FIRST:   return ST_GAP1;
         ST_GAP1:    return ST_PUSH_LO;
         ST_PUSH_LO: return ST_PUSH_HI;
         ST_PUSH_HI: return ST_PUSH_X;
         ST_PUSH_X:  return ST_VEC_HI;
         ST_VEC_HI:  return ST_VEC_LO;
         ST_VEC_LO:  return ST_GAP2;
         ST_GAP2:    return ST_FETCH;
         default:    return ST_IDLE;
      endcase
   endfunction

   // true when the step occupies the bus
   function automatic logic step_is_bus(step_e s, logic skip_first);
      case (s)
         ST_FIRST:                         return !skip_first;
         ST_PUSH_LO, ST_PUSH_HI, ST_PUSH_X: return 1'b1;
         ST_VEC_HI, ST_VEC_LO, ST_FETCH:   return 1'b1;
         default:                          return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/exc_step_ctl.sv
module exc_step_ctl
   import exc_seq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [1:0]  req_kind,
   input  logic        wake_in,
   input  logic        bus_ack,
   output step_e       step_o,
   output logic        is_bus_o,
   output logic        advance_o,
   output logic        accept_o
);

   step_e step_q;
   logic  skip_q;
   kind_e kind_w;

   assign kind_w = kind_e'(req_kind);

   // reset kind always wins; other kinds only start from idle (R9, R10)
   assign accept_o  = req_valid &&
                      ((kind_w == KIND_RESET) ||
                       ((step_q == ST_IDLE) && (kind_w == KIND_IRQ || kind_w == KIND_TRAP)));
   assign is_bus_o  = step_is_bus(step_q, skip_q);
   assign advance_o = (step_q != ST_IDLE) && (!is_bus_o || bus_ack);
   assign step_o    = step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= ST_IDLE;
         skip_q <= 1'b0;
      end else if (accept_o) begin
         step_q <= (kind_w == KIND_RESET) ? ST_VEC_HI : ST_FIRST;
         skip_q <= (kind_w == KIND_IRQ) && wake_in;
      end else if (advance_o) begin
         step_q <= step_after(step_q);
      end
   end

   // R3: an internal state never lasts longer than one cycle
   p_gap_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((step_q == ST_GAP1 || step_q == ST_GAP2 || (step_q == ST_FIRST && skip_q)) && !accept_o)
      |=> (step_q != $past(step_q)));

   // R2: without a new request the step either holds or moves to its successor
   p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((step_q != ST_IDLE) && !accept_o)
      |=> ((step_q == $past(step_q)) || (step_q == step_after($past(step_q)))));

endmodule

// File: rtl/exc_bus_drv.sv
module exc_bus_drv
   import exc_seq_pkg::*;
#(
   parameter int             AW             = 32,
   parameter int             DW             = 16,
   parameter int             VW             = 8,
   parameter logic [AW-1:0]  VEC_BASE       = '0,
   parameter bit             RESET_AT_TABLE = 1'b1,
   parameter logic [AW-1:0]  RESET_VEC      = '0
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           accept_i,
   input  logic [1:0]     kind_i,
   input  logic [AW-1:0]  pc_i,
   input  logic [AW-1:0]  sp_i,
   input  logic [DW-1:0]  xsr_i,
   input  logic [VW-1:0]  vec_i,
   input  step_e          step_i,
   input  logic           advance_i,
   input  logic [DW-1:0]  rdata_i,
   output logic [AW-1:0]  addr_o,
   output logic           we_o,
   output logic [DW-1:0]  wdata_o,
   output logic           lock_o,
   output logic [AW-1:0]  sp_o,
   output logic [AW-1:0]  handler_o
);

   localparam int            VEC_BYTES = AW / 8;
   localparam int            VSH       = $clog2(VEC_BYTES);
   localparam logic [AW-1:0] WORD_B    = AW'(DW / 8);
   localparam logic [AW-1:0] RST_ADDR  = RESET_AT_TABLE ? VEC_BASE : RESET_VEC;

   logic [AW-1:0] pc_q, sp_q, vaddr_q;
   logic [DW-1:0] xsr_q, vhi_q, vlo_q;
   logic          irq_q;
   logic          is_push;

   assign is_push = (step_i == ST_PUSH_LO) || (step_i == ST_PUSH_HI) || (step_i == ST_PUSH_X);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         sp_q    <= '0;
         vaddr_q <= '0;
         xsr_q   <= '0;
         vhi_q   <= '0;
         vlo_q   <= '0;
         irq_q   <= 1'b0;
      end else if (accept_i) begin
         pc_q    <= pc_i;
         sp_q    <= sp_i;
         xsr_q   <= xsr_i;
         irq_q   <= (kind_e'(kind_i) == KIND_IRQ);
         vaddr_q <= (kind_e'(kind_i) == KIND_RESET) ? RST_ADDR
                                                    : (VEC_BASE + (AW'(vec_i) << VSH));
      end else if (advance_i) begin
         if (is_push)                sp_q  <= sp_q - WORD_B;
         if (step_i == ST_VEC_HI)    vhi_q <= rdata_i;
         if (step_i == ST_VEC_LO)    vlo_q <= rdata_i;
      end
   end

   always_comb begin
      addr_o  = '0;
      wdata_o = '0;
      case (step_i)
         ST_FIRST:   addr_o = irq_q ? (pc_q + WORD_B) : pc_q;
         ST_PUSH_LO: begin addr_o = sp_q - WORD_B; wdata_o = pc_q[DW-1:0];  end
         ST_PUSH_HI: begin addr_o = sp_q - WORD_B; wdata_o = pc_q[AW-1:DW]; end
         ST_PUSH_X:  begin addr_o = sp_q - WORD_B; wdata_o = xsr_q;         end
         ST_VEC_HI:  addr_o = vaddr_q;
         ST_VEC_LO:  addr_o = vaddr_q + WORD_B;
         ST_FETCH:   addr_o = {vhi_q, vlo_q};
         default:    addr_o = '0;
      endcase
   end

   assign we_o      = is_push;
   assign lock_o    = (step_i == ST_VEC_HI);
   assign sp_o      = sp_q;
   assign handler_o = {vhi_q, vlo_q};

   // R5: every completed push lowers the stack pointer by one word
   p_sp_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_push && advance_i && !accept_i) |=> (sp_q == $past(sp_q) - WORD_B));

   // R6: the locked read is followed by an unlocked read one word higher
   p_lock_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_o && advance_i && !accept_i) |=> (!lock_o && addr_o == $past(addr_o) + WORD_B));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_seq_pkg::*;
#(
   parameter int             AW             = 32,
   parameter int             DW             = 16,
   parameter int             VW             = 8,
   parameter logic [AW-1:0]  VEC_BASE       = '0,
   parameter bit             RESET_AT_TABLE = 1'b1,
   parameter logic [AW-1:0]  RESET_VEC      = '0
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic [1:0]     req_kind,
   input  logic           wake_from_sleep,
   input  logic [AW-1:0]  pc_in,
   input  logic [AW-1:0]  sp_in,
   input  logic [DW-1:0]  xsr_in,
   input  logic [VW-1:0]  vec_num,
   output logic           bus_req,
   output logic [AW-1:0]  bus_addr,
   output logic           bus_we,
   output logic           bus_size,
   output logic           bus_lock,
   output logic [DW-1:0]  bus_wdata,
   input  logic [DW-1:0]  bus_rdata,
   input  logic           bus_ack,
   output logic           idle_state,
   output logic           busy,
   output logic           done,
   output logic [AW-1:0]  pc_out,
   output logic [AW-1:0]  sp_out
);

   generate
      if (AW != 2 * DW) begin : g_bad_width
         $error("address width must be twice the data width");
      end
      if ((DW % 8) != 0) begin : g_bad_bytes
         $error("data width must be whole bytes");
      end
      if (VW + $clog2(AW / 8) > AW) begin : g_bad_vec
         $error("vector number too wide for address");
      end
   endgenerate

   step_e step;
   logic  is_bus, advance, accept;

   exc_step_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .wake_in   (wake_from_sleep),
      .bus_ack   (bus_ack),
      .step_o    (step),
      .is_bus_o  (is_bus),
      .advance_o (advance),
      .accept_o  (accept)
   );

   exc_bus_drv #(
      .AW             (AW),
      .DW             (DW),
      .VW             (VW),
      .VEC_BASE       (VEC_BASE),
      .RESET_AT_TABLE (RESET_AT_TABLE),
      .RESET_VEC      (RESET_VEC)
   ) u_drv (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_i  (accept),
      .kind_i    (req_kind),
      .pc_i      (pc_in),
      .sp_i      (sp_in),
      .xsr_i     (xsr_in),
      .vec_i     (vec_num),
      .step_i    (step),
      .advance_i (advance),
      .rdata_i   (bus_rdata),
      .addr_o    (bus_addr),
      .we_o      (bus_we),
      .wdata_o   (bus_wdata),
      .lock_o    (bus_lock),
      .sp_o      (sp_out),
      .handler_o (pc_out)
   );

   assign bus_req    = is_bus;
   assign bus_size   = 1'b1;
   assign busy       = (step != ST_IDLE);
   assign idle_state = busy && !is_bus;
   assign done       = (step == ST_FETCH) && bus_ack;

   logic rst_abort;
   assign rst_abort = req_valid && (kind_e'(req_kind) == KIND_RESET);

   // R7: an unacknowledged cycle is held unchanged
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack && !rst_abort)
      |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

   // R8: done only with an acknowledged, unlocked read
   p_done_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bus_req && bus_ack && !bus_we && !bus_lock));

   // R8: done is a single-cycle pulse
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rst_abort) |=> !done);

endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 16;
   localparam int VW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = 2'd3;
   logic          wake_from_sleep = 1'b0;
   logic [AW-1:0] pc_in = '0;
   logic [AW-1:0] sp_in = '0;
   logic [DW-1:0] xsr_in = '0;
   logic [VW-1:0] vec_num = '0;
   logic          bus_req, bus_we, bus_size, bus_lock;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic          bus_ack = 1'b0;
   logic          idle_state, busy, done;
   logic [AW-1:0] pc_out, sp_out;

   always #(CLK_PERIOD / 2) clk = ~clk;

   exc_entry_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .wake_from_sleep(wake_from_sleep), .pc_in(pc_in), .sp_in(sp_in),
      .xsr_in(xsr_in), .vec_num(vec_num), .bus_req(bus_req), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_size(bus_size), .bus_lock(bus_lock),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
      .idle_state(idle_state), .busy(busy), .done(done),
      .pc_out(pc_out), .sp_out(sp_out)
   );

   // memory model: each word's content is a function of its address
   function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
      return a[15:0] ^ 16'h5A3C ^ {a[23:16], a[31:24]};
   endfunction
   assign bus_rdata = mem_word(bus_addr);

   typedef struct {
      bit            isint;
      logic [AW-1:0] addr;
      bit            we;
      logic [DW-1:0] wd;
      bit            lock;
      bit            last;
      int            rq;
   } item_t;

   item_t expq[$];
   int    errors = 0;
   int    checks = 0;
   bit    stall_mode = 1'b0;
   bit    force_stall = 1'b0;
   int    ack_cnt = 0;
   bit    hold_prev = 1'b0;
   logic [AW-1:0] prev_addr = '0;

   task automatic chk(bit ok, int rq, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic put(bit isint, logic [AW-1:0] a, bit we, logic [DW-1:0] wd,
                      bit lock, bit last, int rq);
      item_t it;
      it.isint = isint; it.addr = a; it.we = we; it.wd = wd;
      it.lock = lock; it.last = last; it.rq = rq;
      expq.push_back(it);
   endtask

   // expected step list from the requirements (R1, R2, R3, R4, R5, R6, R8)
   task automatic expect_seq(int kind, logic [AW-1:0] pc, logic [AW-1:0] sp,
                             logic [DW-1:0] xsr, logic [VW-1:0] vn, bit wake, int rq);
      logic [AW-1:0] va, hnd;
      if (kind != 0) begin
         if (kind == 1 && wake) put(1, '0, 0, '0, 0, 0, rq);
         else                   put(0, (kind == 1) ? pc + 2 : pc, 0, '0, 0, 0, rq);
         put(1, '0, 0, '0, 0, 0, rq);
         put(0, sp - 2, 1, pc[15:0],  0, 0, rq);
         put(0, sp - 4, 1, pc[31:16], 0, 0, rq);
         put(0, sp - 6, 1, xsr,       0, 0, rq);
         va = {22'd0, vn, 2'b00};
      end else begin
         va = '0;
      end
      hnd = {mem_word(va), mem_word(va + 2)};
      put(0, va, 0, '0, 1, 0, rq);
      put(0, va + 2, 0, '0, 0, 0, rq);
      put(1, '0, 0, '0, 0, 0, rq);
      put(0, hnd, 0, '0, 0, 1, rq);
   endtask

   task automatic start(int kind, logic [AW-1:0] pc, logic [AW-1:0] sp,
                        logic [DW-1:0] xsr, logic [VW-1:0] vn, bit wake, int rq);
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'(kind); pc_in = pc; sp_in = sp;
      xsr_in = xsr; vec_num = vn; wake_from_sleep = wake;
      expect_seq(kind, pc, sp, xsr, vn, wake, rq);
      @(negedge clk);
      req_valid = 1'b0; req_kind = 2'd3;
   endtask

   task automatic wait_idle();
      do begin
         @(negedge clk);
         #4;
      end while (busy || expq.size() != 0);
   endtask

   // monitor: sets the acknowledge, then compares each step with the queue
   always @(negedge clk) begin
      #2;
      ack_cnt++;
      bus_ack = force_stall ? 1'b0 : (stall_mode ? (ack_cnt % 3 == 0) : 1'b1);
      #1;
      if (rst_n) begin
         if (hold_prev)   // R7 held cycle
            chk(bus_req && bus_addr == prev_addr, 7, "held cycle changed",
                {31'd0, bus_req, bus_addr}, {31'd0, 1'b1, prev_addr});
         hold_prev = bus_req && !bus_ack && !(req_valid && req_kind == 2'd0);
         prev_addr = bus_addr;
         if (bus_req && bus_ack) begin
            if (expq.size() == 0) begin
               chk(0, 2, "unexpected bus cycle", {32'd0, bus_addr}, '0);
            end else begin
               item_t it;
               it = expq.pop_front();
               chk(!it.isint && bus_we == it.we && bus_lock == it.lock && bus_size &&
                   bus_addr == it.addr && (!it.we || bus_wdata == it.wd),
                   it.rq, "bus cycle",
                   {12'd0, it.isint ? 1'b0 : 1'b1, bus_we, bus_lock, bus_size, bus_addr, bus_wdata},
                   {12'd0, it.isint ? 1'b1 : 1'b1, it.we, it.lock, 1'b1, it.addr, it.we ? it.wd : bus_wdata});
               chk(done == it.last, 8, "done at fetch", {63'd0, done}, {63'd0, it.last});
            end
         end else if (idle_state) begin
            if (expq.size() == 0) begin
               chk(0, 3, "unexpected internal state", '0, '0);
            end else begin
               item_t it;
               it = expq.pop_front();
               chk(it.isint, it.rq, "internal state in place of bus cycle",
                   {32'd0, bus_addr}, {32'd0, it.addr});
            end
         end else if (done) begin
            chk(0, 8, "stray done", 64'd1, 64'd0);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: idle after reset
      chk(!bus_req && !busy && !idle_state && !done, 11, "reset state",
          {60'd0, bus_req, busy, idle_state, done}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset entry
      start(0, 32'h0000_1000, 32'h0000_4000, 16'h0000, 8'd0, 1'b0, 1);
      wait_idle();
      chk(pc_out == {mem_word(32'd0), mem_word(32'd2)}, 8, "handler after reset",
          {32'd0, pc_out}, {32'd0, mem_word(32'd0), mem_word(32'd2)});

      // R2 R5 R6: interrupt, prompt acknowledge
      start(1, 32'h0001_2340, 32'h0000_8000, 16'h0703, 8'd25, 1'b0, 2);
      wait_idle();
      chk(sp_out == 32'h0000_7FFA, 5, "stack after pushes", {32'd0, sp_out}, 64'h7FFA);
      chk(pc_out == {mem_word(32'd100), mem_word(32'd102)}, 8, "handler address",
          {32'd0, pc_out}, {32'd0, mem_word(32'd100), mem_word(32'd102)});

      // R3 R7: wake from sleep with stretched acknowledge
      stall_mode = 1'b1;
      start(1, 32'h00AB_CDE0, 32'h0001_0000, 16'h8001, 8'd40, 1'b1, 3);
      wait_idle();
      stall_mode = 1'b0;

      // R4: trap, wake flag must not matter
      start(2, 32'h0000_2002, 32'h0000_6000, 16'h1234, 8'd9, 1'b1, 4);
      wait_idle();

      // R6: highest vector number
      start(1, 32'hFFFF_FFF0, 32'h0000_0100, 16'hFFFF, 8'd255, 1'b0, 6);
      wait_idle();
      chk(sp_out == 32'h0000_00FA, 5, "stack after pushes", {32'd0, sp_out}, 64'hFA);

      // R10: requests while busy are ignored
      start(1, 32'h0003_0000, 32'h0000_9000, 16'h00AA, 8'd7, 1'b0, 10);
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd2; pc_in = 32'h0BAD_0000; sp_in = 32'h0000_1110;
      xsr_in = 16'hDEAD; vec_num = 8'd3;
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd1;
      @(negedge clk);
      req_valid = 1'b0; req_kind = 2'd3;
      wait_idle();
      chk(sp_out == 32'h0000_8FFA, 10, "operands kept", {32'd0, sp_out}, 64'h8FFA);
      @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd3;
      @(negedge clk);
      req_valid = 1'b0;
      #4;
      chk(!busy && !bus_req, 10, "kind 3 ignored", {62'd0, busy, bus_req}, 64'd0);

      // R9: reset request in the middle of a push
      start(1, 32'h0004_4440, 32'h0000_A000, 16'h0055, 8'd60, 1'b0, 2);
      do @(negedge clk); while (!(bus_req && bus_we));
      force_stall = 1'b1;
      req_valid = 1'b1; req_kind = 2'd0;
      expq.delete();
      expect_seq(0, '0, '0, '0, '0, 1'b0, 9);
      @(negedge clk);
      req_valid = 1'b0; req_kind = 2'd3; force_stall = 1'b0;
      wait_idle();
      chk(pc_out == {mem_word(32'd0), mem_word(32'd2)}, 9, "handler after abort",
          {32'd0, pc_out}, {32'd0, mem_word(32'd0), mem_word(32'd2)});

      repeat (3) @(negedge clk);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule